// File: doc/BRIEF.md
# USB Full-Speed Bus Line State Monitor

This block watches the decoded full-speed line state of a USB port and turns long runs of particular states into one-cycle event pulses. A line decoder upstream presents the state on a two-bit input together with a sampling strobe. A free-running timer supplies a separate one-millisecond strobe. Both strobes come from outside, so the block does not depend on any particular clock frequency.

In device mode the monitor finds a bus reset from a long run of SE0. It signals the reset when the line goes back to idle (J), not when SE0 begins. It also reports suspend when the line has stayed idle for three milliseconds. In host mode it keeps a level showing whether a device is attached. A run of J while detached gives a connect pulse, and a run of SE0 while attached gives a disconnect pulse. The role is read from a mode pin while the block is held in reset, and it stays fixed until the next reset.

Top module: `usb_line_monitor`

## Requirements
- R1: Line state encoding is 2'b00 = SE0, 2'b01 = J (idle), 2'b10 = K, 2'b11 = SE1. In device mode, a bus reset qualifies only after RST_SAMPLES (default 60) consecutive strobed SE0 samples. A shorter SE0 run followed by J produces no reset pulse.
- R2: The device reset pulse lasts one cycle. It is raised on the first strobed J sample after a qualifying SE0 run, and never while SE0 is still present.
- R3: In device mode, `suspend_o` pulses when SUSP_MS (default 3) millisecond strobes have arrived with no strobed sample other than J in between.
- R4: Suspend is reported once per idle period. Any strobed non-J sample restarts the idle timer and rearms the report.
- R5: In host mode while detached, HOST_SAMPLES (default 22) consecutive J samples produce a one-cycle `connect_o` pulse, and `attached_o` rises in the same cycle. Further J samples give no more pulses.
- R6: In host mode while attached, HOST_SAMPLES consecutive SE0 samples produce a one-cycle `disconnect_o` pulse, and `attached_o` falls in the same cycle.
- R7: A strobed sample that differs from the state being counted clears that run count to zero, so runs do not add up across an interruption.
- R8: The role (0 = device, 1 = host) is captured only while `rst_n` is low. Device events never occur in host mode, and host events never occur in device mode.
- R9: While in reset and right after it, every event output and `attached_o` is 0.
- R10: Each event output is registered. It is high in the cycle after the clock edge that accepted the deciding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; role is captured while low |
| host_mode_i | input | 1 | Role select: 0 device, 1 host |
| sample_tick_i | input | 1 | Strobe: line_state_i holds a valid sample |
| ms_tick_i | input | 1 | One-millisecond strobe |
| line_state_i | input | 2 | Decoded line state (SE0/J/K/SE1) |
| bus_reset_o | output | 1 | Device: reset released pulse |
| suspend_o | output | 1 | Device: suspend pulse |
| connect_o | output | 1 | Host: device connect pulse |
| disconnect_o | output | 1 | Host: device disconnect pulse |
| attached_o | output | 1 | Host: device attached level |

## Verification
The bench builds the block with its default thresholds of 60, 22 and 3. It asserts the sample strobe on every clock, so each sample takes one cycle, and a full reset run or attach run takes only tens of cycles. The tests probe runs exactly one sample short of each threshold and exactly at it. They also break runs partway through, check that suspend fires once over a long idle stretch, and flip the role pin outside reset to show that the captured role is kept.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_state_t;
endpackage

// File: rtl/usb_lm_run_cnt.sv
module usb_lm_run_cnt #(
   parameter int THRESH = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic match_i,
   output logic reached_o
);
   localparam int W = $clog2(THRESH + 1);
   localparam logic [W-1:0] LAST = W'(THRESH - 1);
   localparam logic [W-1:0] FULL = W'(THRESH);

   generate
      if (THRESH < 2) begin : g_bad
         $error("usb_lm_run_cnt: THRESH must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (!match_i)          cnt_q <= '0;
         else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign reached_o = tick_i && match_i && (cnt_q == LAST);
endmodule

// File: rtl/usb_lm_device.sv
module usb_lm_device
   import usb_lm_pkg::*;
#(
   parameter int SUSP_MS = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en_i,
   input  logic        tick_i,
   input  logic        ms_tick_i,
   input  line_state_t line_i,
   input  logic        se0_long_i,
   output logic        bus_reset_o,
   output logic        suspend_o
);
   localparam int MW = $clog2(SUSP_MS + 1);
   localparam logic [MW-1:0] MS_LAST = MW'(SUSP_MS - 1);
   localparam logic [MW-1:0] MS_FULL = MW'(SUSP_MS);

   generate
      if (SUSP_MS < 1) begin : g_bad
         $error("usb_lm_device: SUSP_MS must be at least 1");
      end
   endgenerate

   logic          armed_q;
   logic [MW-1:0] idle_ms_q;
   logic          busy;
   logic          rel;

   assign busy = tick_i && (line_i != LS_J);
   assign rel  = tick_i && (line_i == LS_J) && armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         bus_reset_o <= 1'b0;
      end else begin
         bus_reset_o <= en_i && rel;
         if (!en_i)           armed_q <= 1'b0;
         else if (se0_long_i) armed_q <= 1'b1;
         else if (rel)        armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_ms_q <= '0;
         suspend_o <= 1'b0;
      end else begin
         suspend_o <= en_i && ms_tick_i && !busy && (idle_ms_q == MS_LAST);
         if (busy)
            idle_ms_q <= '0;
         else if (ms_tick_i && idle_ms_q != MS_FULL)
            idle_ms_q <= idle_ms_q + 1'b1;
      end
   end
endmodule

// File: rtl/usb_lm_host.sv
module usb_lm_host (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic j_run_i,
   input  logic se0_run_i,
   output logic connect_o,
   output logic disconnect_o,
   output logic attached_o
);
   logic go_on;
   logic go_off;

   assign go_on  = en_i && !attached_o && j_run_i;
   assign go_off = en_i && attached_o && se0_run_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attached_o   <= 1'b0;
         connect_o    <= 1'b0;
         disconnect_o <= 1'b0;
      end else begin
         connect_o    <= go_on;
         disconnect_o <= go_off;
         if (go_on)       attached_o <= 1'b1;
         else if (go_off) attached_o <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
   import usb_lm_pkg::*;
#(
   parameter int RST_SAMPLES  = 60,
   parameter int HOST_SAMPLES = 22,
   parameter int SUSP_MS      = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_mode_i,
   input  logic       sample_tick_i,
   input  logic       ms_tick_i,
   input  logic [1:0] line_state_i,
   output logic       bus_reset_o,
   output logic       suspend_o,
   output logic       connect_o,
   output logic       disconnect_o,
   output logic       attached_o
);
   generate
      if (RST_SAMPLES <= HOST_SAMPLES) begin : g_bad_thr
         $error("usb_line_monitor: RST_SAMPLES must exceed HOST_SAMPLES");
      end
   endgenerate

   line_state_t ls;
   logic        host_q;
   logic        se0_long, se0_short, j_short;

   assign ls = line_state_t'(line_state_i);

   always_ff @(posedge clk) begin
      if (!rst_n) host_q <= host_mode_i;
   end

   usb_lm_run_cnt #(.THRESH(RST_SAMPLES)) u_se0_long (
      .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i),
      .match_i(ls == LS_SE0), .reached_o(se0_long));

   usb_lm_run_cnt #(.THRESH(HOST_SAMPLES)) u_se0_short (
      .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i),
      .match_i(ls == LS_SE0), .reached_o(se0_short));

   usb_lm_run_cnt #(.THRESH(HOST_SAMPLES)) u_j_short (
      .clk(clk), .rst_n(rst_n), .tick_i(sample_tick_i),
      .match_i(ls == LS_J), .reached_o(j_short));

   usb_lm_device #(.SUSP_MS(SUSP_MS)) u_dev (
      .clk(clk), .rst_n(rst_n), .en_i(!host_q), .tick_i(sample_tick_i),
      .ms_tick_i(ms_tick_i), .line_i(ls), .se0_long_i(se0_long),
      .bus_reset_o(bus_reset_o), .suspend_o(suspend_o));

   usb_lm_host u_host (
      .clk(clk), .rst_n(rst_n), .en_i(host_q),
      .j_run_i(j_short), .se0_run_i(se0_short),
      .connect_o(connect_o), .disconnect_o(disconnect_o),
      .attached_o(attached_o));
endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_q,
   input logic       sample_tick_i,
   input logic [1:0] line_state_i,
   input logic       bus_reset_o,
   input logic       suspend_o,
   input logic       connect_o,
   input logic       disconnect_o,
   input logic       attached_o
);
   assert_reset_on_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_o |-> ($past(sample_tick_i) && $past(line_state_i) == 2'b01));
   assert_reset_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_o |=> !bus_reset_o);
   assert_suspend_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |=> !suspend_o);
   assert_connect_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(attached_o) |-> connect_o);
   assert_disconnect_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(attached_o) |-> disconnect_o);
   assert_role_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_q |-> (!bus_reset_o && !suspend_o));
   assert_role_split_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !host_q |-> (!connect_o && !disconnect_o && !attached_o));
   assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_reset_o, suspend_o, connect_o, disconnect_o}));
endmodule

bind usb_line_monitor usb_line_monitor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_q(host_q),
   .sample_tick_i(sample_tick_i), .line_state_i(line_state_i),
   .bus_reset_o(bus_reset_o), .suspend_o(suspend_o),
   .connect_o(connect_o), .disconnect_o(disconnect_o),
   .attached_o(attached_o));

// File: tb/usb_line_monitor_tb.sv
module usb_line_monitor_tb;
   localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

   typedef struct packed {
      logic       mode;
      logic [1:0] ls;
      logic [7:0] n;
      logic       ms;
      logic [1:0] e_rst, e_sus, e_con, e_dis;
      logic       e_att;
   } row_t;

   localparam int NROW = 24;
   localparam row_t TBL [NROW] = '{
      '{1'b0, J,   8'd5,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 0  R9 idle
      '{1'b0, SE0, 8'd59, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 1  R1
      '{1'b0, J,   8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 2  R1 short run
      '{1'b0, SE0, 8'd60, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 3  R2 no onset pulse
      '{1'b0, J,   8'd1,  1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0}, // 4  R2 release
      '{1'b0, J,   8'd2,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 5  R3 2 ms
      '{1'b0, J,   8'd1,  1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0}, // 6  R3 3 ms
      '{1'b0, J,   8'd4,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 7  R4 once
      '{1'b0, K,   8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 8  R4 traffic
      '{1'b0, J,   8'd3,  1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0}, // 9  R4 rearmed
      '{1'b0, SE0, 8'd30, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 10 R7
      '{1'b0, K,   8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 11 R7 break
      '{1'b0, SE0, 8'd40, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 12 R7
      '{1'b0, J,   8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 13 R7 no reset
      '{1'b1, J,   8'd21, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 14 R5 short
      '{1'b1, SE0, 8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 15 R7 break
      '{1'b1, J,   8'd22, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 1'b1}, // 16 R5 connect
      '{1'b1, J,   8'd10, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1}, // 17 R5 once
      '{1'b1, SE0, 8'd21, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1}, // 18 R6 short
      '{1'b1, J,   8'd1,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1}, // 19 R7 break
      '{1'b1, SE0, 8'd22, 1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 1'b0}, // 20 R6 disconnect
      '{1'b1, SE0, 8'd60, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 21 R8
      '{1'b1, J,   8'd1,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}, // 22 R8 no reset
      '{1'b1, J,   8'd5,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0}  // 23 R8 no suspend
   };

   function automatic string row_req(int i);
      case (i)
         0: return "R9";
         1, 2: return "R1";
         3, 4: return "R2";
         5, 6: return "R3";
         7, 8, 9: return "R4";
         10, 11, 12, 13, 15, 19: return "R7";
         14, 16, 17: return "R5";
         18, 20: return "R6";
         default: return "R8";
      endcase
   endfunction

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_mode_i = 1'b0;
   logic       sample_tick_i = 1'b0;
   logic       ms_tick_i = 1'b0;
   logic [1:0] line_state_i = J;
   logic       bus_reset_o, suspend_o, connect_o, disconnect_o, attached_o;

   int n_chk = 0, n_bad = 0;
   int c_rst, c_sus, c_con, c_dis;
   bit done = 0;

   always #2 clk = ~clk;

   usb_line_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode_i),
      .sample_tick_i(sample_tick_i), .ms_tick_i(ms_tick_i),
      .line_state_i(line_state_i), .bus_reset_o(bus_reset_o),
      .suspend_o(suspend_o), .connect_o(connect_o),
      .disconnect_o(disconnect_o), .attached_o(attached_o));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; host_mode_i = mode; sample_tick_i = 1'b0; ms_tick_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R9", "outputs in reset",
            {bus_reset_o, suspend_o, connect_o, disconnect_o, attached_o}, 0);
      rst_n = 1'b1;
   endtask

   task automatic smp(input logic [1:0] ls, input logic ms);
      @(negedge clk);
      line_state_i = ls; sample_tick_i = 1'b1; ms_tick_i = ms;
      @(posedge clk);
      #1;
      sample_tick_i = 1'b0; ms_tick_i = 1'b0;
      c_rst += int'(bus_reset_o); c_sus += int'(suspend_o);
      c_con += int'(connect_o);   c_dis += int'(disconnect_o);
   endtask

   task automatic clr_counts();
      c_rst = 0; c_sus = 0; c_con = 0; c_dis = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic cur_mode;
      cur_mode = 1'b0;
      do_reset(1'b0);
      @(negedge clk);
      check("R9", "outputs after reset",
            {bus_reset_o, suspend_o, connect_o, disconnect_o, attached_o}, 0);

      for (int i = 0; i < NROW; i++) begin
         if (TBL[i].mode != cur_mode) begin
            cur_mode = TBL[i].mode;
            do_reset(cur_mode);
         end
         clr_counts();
         for (int k = 0; k < int'(TBL[i].n); k++) smp(TBL[i].ls, TBL[i].ms);
         check(row_req(i), $sformatf("row %0d bus_reset pulses", i), c_rst, int'(TBL[i].e_rst));
         check(row_req(i), $sformatf("row %0d suspend pulses", i), c_sus, int'(TBL[i].e_sus));
         check(row_req(i), $sformatf("row %0d connect pulses", i), c_con, int'(TBL[i].e_con));
         check(row_req(i), $sformatf("row %0d disconnect pulses", i), c_dis, int'(TBL[i].e_dis));
         check(row_req(i), $sformatf("row %0d attached", i), int'(attached_o), int'(TBL[i].e_att));
      end

      // R8: role pin changes outside reset are ignored
      do_reset(1'b0);
      host_mode_i = 1'b1;
      clr_counts();
      for (int k = 0; k < 22; k++) smp(J, 1'b0);
      check("R8", "connect with pin flipped", c_con, 0);
      check("R8", "attached with pin flipped", int'(attached_o), 0);
      clr_counts();
      for (int k = 0; k < 60; k++) smp(SE0, 1'b0);
      smp(J, 1'b0);
      check("R8", "device reset still active", c_rst, 1);

      // R10: pulse timing relative to the deciding strobe
      do_reset(1'b0);
      for (int k = 0; k < 60; k++) smp(SE0, 1'b0);
      @(negedge clk);
      line_state_i = J; sample_tick_i = 1'b1;
      @(posedge clk);
      #1;
      sample_tick_i = 1'b0;
      check("R10", "reset pulse cycle after strobe", int'(bus_reset_o), 1);
      @(posedge clk);
      #1;
      check("R10", "reset pulse one cycle wide", int'(bus_reset_o), 0);

      finish_run();
   end
endmodule